// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

A combinational binary adder that sums two operands and a carry-in into a sum and a carry-out. The operand width is split into equal slices (four slices of four bits by default). Inside each slice, the carry into every bit is formed as a flattened sum-of-products. Each term is built from the per-bit generate (`a & b`) and propagate (`a ^ b`) signals and the slice carry-in, so no carry passes from bit to bit. Each slice also reports a group generate and a group propagate.

A second-level lookahead unit takes the group signals together with the adder carry-in. It forms every slice carry-in at once, in the same sum-of-products form, so carries do not ripple across slices either. A parameter can instead chain each slice's carry-out into the next slice. That variant trades speed for a shallower second level and gives the same results. The block is meant to sit inside a registered datapath stage. It has no state and no reset.

Top module: `cla_adder`

## Requirements
- R1: `{cout_o, sum_o}` equals the (WIDTH+1)-bit value `a_i + b_i + cin_i` for every input combination when the carry mode is lookahead.
- R2: With the carry mode set to ripple, `sum_o` and `cout_o` are bit-for-bit identical to the lookahead mode for every input combination.
- R3: When one slice generates a carry and every bit above it propagates, that carry reaches all higher bits and `cout_o`. Example: `a_i = 16'hFFFF << 4k`, `b_i = 16'h0001 << 4k`, with `k` the generating slice, gives `sum_o = 0` and `cout_o = 1`.
- R4: When every bit propagates (`a_i ^ b_i` all ones), `cout_o` equals `cin_i` and `sum_o` equals all ones when `cin_i = 0` and all zeros when `cin_i = 1`.
- R5: A slice whose bits neither generate nor propagate (`a_i` and `b_i` both zero across the slice) stops a carry from below. Example: `a_i = 16'hFF0F`, `b_i = 16'h0001`, `cin_i = 0` gives `sum_o = 16'hFF10` and `cout_o = 0`.
- R6: The carry-in alone is added: zero operands with `cin_i = 1` give `sum_o = 1`, `cout_o = 0`; with `cin_i = 0` the result is all zeros.
- R7: The largest operands `16'hFFFF + 16'hFFFF + 1` give `sum_o = 16'hFFFF` and `cout_o = 1`; without the carry-in they give `sum_o = 16'hFFFE` and `cout_o = 1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH (16) | First operand |
| b_i | input | WIDTH (16) | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH (16) | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
Every result is purely combinational. It is due in the same cycle as the operands, with no register between an input and an output. The bench changes the inputs one time unit after a rising edge and reads the sum and carry-out at the following falling edge, when the logic has settled. It applies each vector to a lookahead instance and a ripple instance side by side. It compares both against a (WIDTH+1)-bit reference sum computed in the bench.

// File: rtl/cla_pkg.sv
package cla_pkg;
  typedef enum logic {
    CARRY_RIPPLE    = 1'b0,
    CARRY_LOOKAHEAD = 1'b1
  } carry_mode_e;
endpackage

// File: rtl/cla_lookahead.sv
// Flattened sum-of-products carry unit, used for bits and for slices alike.
module cla_lookahead #(
  parameter int W = 4
) (
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] p_i,
  input  logic         c_i,
  output logic [W-1:0] c_o,   // c_o[k]: carry out of position k
  output logic         gg_o,
  output logic         pg_o
);
  always_comb begin
    logic term;
    logic acc;
    c_o = '0;
    for (int k = 0; k < W; k++) begin
      term = c_i;
      for (int m = 0; m <= k; m++) term = term & p_i[m];
      acc = term;
      for (int j = 0; j <= k; j++) begin
        term = g_i[j];
        for (int m = j + 1; m <= k; m++) term = term & p_i[m];
        acc = acc | term;
      end
      c_o[k] = acc;
    end
  end

  always_comb begin
    logic term;
    gg_o = 1'b0;
    for (int j = 0; j < W; j++) begin
      term = g_i[j];
      for (int m = j + 1; m < W; m++) term = term & p_i[m];
      gg_o = gg_o | term;
    end
  end

  assign pg_o = &p_i;
endmodule

// File: rtl/cla_slice.sv
module cla_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         gg_o,
  output logic         pg_o
);
  logic [W-1:0] bit_g, bit_p, bit_c, bit_cin;

  assign bit_g = a_i & b_i;
  assign bit_p = a_i ^ b_i;

  cla_lookahead #(.W(W)) u_la (
    .g_i (bit_g),
    .p_i (bit_p),
    .c_i (cin_i),
    .c_o (bit_c),
    .gg_o(gg_o),
    .pg_o(pg_o)
  );

  assign bit_cin = {bit_c[W-2:0], cin_i};
  assign sum_o   = bit_p ^ bit_cin;
  assign cout_o  = bit_c[W-1];
endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int          WIDTH   = 16,
  parameter int          SLICE_W = 4,
  parameter carry_mode_e MODE    = CARRY_LOOKAHEAD
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int NUM_SLICES = WIDTH / SLICE_W;

  logic [NUM_SLICES:0]   slice_c;   // slice_c[k]: carry into slice k
  logic [NUM_SLICES-1:0] slice_co, grp_g, grp_p, la_c;
  logic                  top_gg, top_pg;

  assign slice_c[0] = cin_i;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    cla_slice #(.W(SLICE_W)) u_slice (
      .a_i   (a_i[k*SLICE_W +: SLICE_W]),
      .b_i   (b_i[k*SLICE_W +: SLICE_W]),
      .cin_i (slice_c[k]),
      .sum_o (sum_o[k*SLICE_W +: SLICE_W]),
      .cout_o(slice_co[k]),
      .gg_o  (grp_g[k]),
      .pg_o  (grp_p[k])
    );
  end

  // Second level over the group signals
  cla_lookahead #(.W(NUM_SLICES)) u_grp (
    .g_i (grp_g),
    .p_i (grp_p),
    .c_i (cin_i),
    .c_o (la_c),
    .gg_o(top_gg),
    .pg_o(top_pg)
  );

  if (MODE == CARRY_LOOKAHEAD) begin : g_lookahead
    assign slice_c[NUM_SLICES:1] = la_c;
  end else begin : g_ripple
    assign slice_c[NUM_SLICES:1] = slice_co;
  end

  assign cout_o = slice_c[NUM_SLICES];
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int WIDTH      = 16,
  parameter int NUM_SLICES = 4
) (
  input logic [WIDTH-1:0]      a_i,
  input logic [WIDTH-1:0]      b_i,
  input logic                  cin_i,
  input logic [WIDTH-1:0]      sum_o,
  input logic                  cout_o,
  input logic [NUM_SLICES:0]   slice_c,
  input logic [NUM_SLICES-1:0] slice_co,
  input logic [NUM_SLICES-1:0] grp_g,
  input logic [NUM_SLICES-1:0] grp_p,
  input logic [NUM_SLICES-1:0] la_c,
  input logic                  top_gg,
  input logic                  top_pg
);
  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    a_r1_total_sum: assert ({cout_o, sum_o} == ref_total)
      else $error("R1 sum mismatch");
    a_r4_top_prop: assert (!top_pg || (cout_o == cin_i))
      else $error("R4 full propagate lost carry-in");
    a_r3_top_gen: assert (!top_gg || cout_o)
      else $error("R3 group generate lost");
    for (int k = 0; k < NUM_SLICES; k++) begin
      a_r2_paths_agree: assert (la_c[k] == slice_co[k])
        else $error("R2 slice %0d lookahead and slice carry differ", k);
      a_r3_gen_sets: assert (!grp_g[k] || slice_c[k+1])
        else $error("R3 slice %0d generate not passed", k);
      a_r4_prop_passes: assert (!grp_p[k] || (slice_c[k+1] == slice_c[k]))
        else $error("R4 slice %0d propagate broken", k);
      a_r5_kill_clears: assert (grp_g[k] || grp_p[k] || !slice_c[k+1])
        else $error("R5 slice %0d kill not honoured", k);
    end
  end
endmodule

bind cla_adder cla_adder_chk #(
  .WIDTH     (WIDTH),
  .NUM_SLICES(NUM_SLICES)
) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .cin_i   (cin_i),
  .sum_o   (sum_o),
  .cout_o  (cout_o),
  .slice_c (slice_c),
  .slice_co(slice_co),
  .grp_g   (grp_g),
  .grp_p   (grp_p),
  .la_c    (la_c),
  .top_gg  (top_gg),
  .top_pg  (top_pg)
);

// File: tb/sim_cla_adder.sv
`timescale 1ns/1ps
module sim_cla_adder;
  import cla_pkg::*;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a, b;
  logic         cin;
  logic [W-1:0] sum_la, sum_rp;
  logic         cout_la, cout_rp;
  int           n_checks = 0;
  int           n_fail = 0;

  always #2.5 clk = ~clk;

  cla_adder #(.WIDTH(W), .SLICE_W(4), .MODE(CARRY_LOOKAHEAD)) u0 (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum_la), .cout_o(cout_la)
  );
  cla_adder #(.WIDTH(W), .SLICE_W(4), .MODE(CARRY_RIPPLE)) u1 (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum_rp), .cout_o(cout_rp)
  );

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", req, a, b, cin, act, exp);
    end
  endtask

  // Drive after a rising edge, sample on the falling edge.
  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
    @(posedge clk);
    #1;
    a = av; b = bv; cin = cv;
    @(negedge clk);
  endtask

  function automatic logic [W:0] ref_sum(input logic [W-1:0] av, input logic [W-1:0] bv,
                                         input logic cv);
    return {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
  endfunction

  task automatic t_reset_state;
    apply('0, '0, 1'b0);
    check("R6 zero", {cout_la, sum_la}, '0);
    check("R2 zero", {cout_rp, sum_rp}, '0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] av, bv;
      logic cv;
      av = W'($urandom); bv = W'($urandom); cv = 1'($urandom);
      apply(av, bv, cv);
      check("R1 random", {cout_la, sum_la}, ref_sum(av, bv, cv));
      check("R2 random", {cout_rp, sum_rp}, {cout_la, sum_la});
    end
  endtask

  task automatic t_gen_chain;
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 2; c++) begin
        apply(16'hFFFF << (4 * k), 16'h0001 << (4 * k), 1'(c));
        check("R3 lookahead", {cout_la, sum_la}, {1'b1, 16'h0000} + 17'(c));
        check("R3 ripple", {cout_rp, sum_rp}, {1'b1, 16'h0000} + 17'(c));
      end
    end
  endtask

  task automatic t_all_prop;
    logic [W-1:0] pats [3] = '{16'hAAAA, 16'h0F0F, 16'hFFFF};
    for (int i = 0; i < 3; i++) begin
      apply(pats[i], ~pats[i], 1'b0);
      check("R4 cin0", {cout_la, sum_la}, {1'b0, 16'hFFFF});
      check("R4 ripple cin0", {cout_rp, sum_rp}, {1'b0, 16'hFFFF});
      apply(pats[i], ~pats[i], 1'b1);
      check("R4 cin1", {cout_la, sum_la}, {1'b1, 16'h0000});
      check("R4 ripple cin1", {cout_rp, sum_rp}, {1'b1, 16'h0000});
    end
  endtask

  task automatic t_kill;
    apply(16'hFF0F, 16'h0001, 1'b0);
    check("R5 kill", {cout_la, sum_la}, {1'b0, 16'hFF10});
    check("R5 ripple kill", {cout_rp, sum_rp}, {1'b0, 16'hFF10});
    apply(16'h0FFF, 16'h0001, 1'b1);
    check("R5 kill top", {cout_la, sum_la}, {1'b0, 16'h1001});
  endtask

  task automatic t_extremes;
    apply('0, '0, 1'b1);
    check("R6 cin only", {cout_la, sum_la}, 17'h00001);
    check("R6 ripple cin only", {cout_rp, sum_rp}, 17'h00001);
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    check("R7 max cin1", {cout_la, sum_la}, 17'h1FFFF);
    check("R7 ripple max cin1", {cout_rp, sum_rp}, 17'h1FFFF);
    apply(16'hFFFF, 16'hFFFF, 1'b0);
    check("R7 max cin0", {cout_la, sum_la}, 17'h1FFFE);
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_gen_chain();
    t_all_prop();
    t_kill();
    t_extremes();
    t_random();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule